// File: doc/BRIEF.md
# Multi-Bank Page-Mode DRAM Controller

This block connects a simple valid/ready memory request port to asynchronous page-mode DRAM. It drives an 11-bit address bus that carries the row first and then the column. Each of the four banks has its own active-low row strobe, and all banks share one active-low column strobe. After an access, the row stays open. A later request to the same bank and row therefore needs only a column strobe. A request to another row first spends a cycle precharging.

A static configuration input gives the chip capacity: 256K, 1M or 4M locations. The capacity sets how the byte address splits into column, row and bank. A second static input marks which banks are fitted. Requests to an empty bank finish without strobes and read back all ones. A free-running interval timer raises refresh requests. Each request is served at a transaction boundary as a batch of CAS-before-RAS cycles, and the requester is held off while the batch runs.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, every dram_ras_n bit and dram_cas_n are 1, rd_valid is 0, and no row is open.
- R2: cfg_size picks the side width n: code 0 gives 9, code 1 gives 10, codes 2 and 3 give 11. The column is address bits [n-1:0], the row is bits [2n-1:n], and the bank is the value of the bits from 2n upward. The row is on dram_addr when a bank's RAS falls, and the column is on dram_addr while CAS is low.
- R3: A read returns the byte last written to the same address. A location never written reads 0 in the bench's DRAM model.
- R4: When a request hits the open bank and row, its read data pulse rises on the first clock edge after the accepting edge, and RAS does not change.
- R5: When no row is open, a read's data pulse rises on the second edge after acceptance (open row, then column).
- R6: When a row is open and the request is for another bank or row, one extra precharge cycle with all RAS high comes first, so the data pulse rises on the third edge.
- R7: A request whose bank value is 4 or more, or whose bit in cfg_bank_en is 0, asserts neither RAS nor CAS. It completes with its pulse on the first edge, reads all ones, changes no DRAM content and leaves the open row as it was.
- R8: A refresh request is raised every REF_PERIOD cycles. It starts only when no transaction is in progress. While it runs, req_ready is 0. It precharges and then performs REF_BURST cycles in which CAS is low before, and during, all four RAS lines going low together.
- R9: A refresh batch closes the open row, so the next populated access takes the R5 latency.
- R10: Outside refresh, at most one RAS line is low. rd_valid is a single-cycle pulse and is given only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 2 | Chip capacity code (static) |
| cfg_bank_en | input | 4 | Fitted-bank mask (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 24 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 4 | Per-bank row strobes, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | DRAM write enable, active low |
| dram_wdata | output | DATA_W | Data toward DRAM |
| dram_rdata | input | DATA_W | Data from DRAM |

## Verification
A read's data pulse is due 1, 2 or 3 clock edges after the accepting edge: 1 for a page hit or an empty bank, 2 for a closed page and 3 for a row change. The bench works out which case applies from its own record of the open bank and row. It clears that record whenever it sees all four RAS lines low. It drives inputs on falling edges and counts falling edges from acceptance to the pulse, so the measured latency is the count minus one. The strobe and address checks sample at falling edges during the column cycle. Refresh spacing is measured between the first all-RAS-low cycles of successive batches while the port is idle.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    localparam int DA_W   = 11;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int ADDR_W = BANK_W + 2 * DA_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_NOBANK,
        ST_RPRE,
        ST_RCAS,
        ST_RRAS,
        ST_RREC
    } st_t;

    typedef struct packed {
        logic              populated;
        logic [BANK_W-1:0] bank;
        logic [DA_W-1:0]   row;
        logic [DA_W-1:0]   col;
    } loc_t;

    // Number of row (and column) bits for a capacity code.
    function automatic int unsigned side_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return 9;
            2'd1:    return 10;
            default: return 11;
        endcase
    endfunction

    function automatic loc_t split_addr(input logic [ADDR_W-1:0] a,
                                        input logic [1:0]        sz,
                                        input logic [NBANK-1:0]  mask);
        loc_t              r;
        logic [ADDR_W-1:0] cm;
        logic [ADDR_W-1:0] ext;
        int unsigned       n;
        n           = side_bits(sz);
        cm          = (ADDR_W'(1) << n) - ADDR_W'(1);
        r.col       = DA_W'(a & cm);
        r.row       = DA_W'((a >> n) & cm);
        ext         = a >> (2 * n);
        r.bank      = ext[BANK_W-1:0];
        r.populated = (ext < ADDR_W'(NBANK)) && mask[ext[BANK_W-1:0]];
        return r;
    endfunction

    function automatic logic in_refresh(input st_t s);
        return (s == ST_RPRE) || (s == ST_RCAS) || (s == ST_RRAS) || (s == ST_RREC);
    endfunction

endpackage

// File: rtl/pgdram_addr_map.sv
module pgdram_addr_map
    import pgdram_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cfg_size,
    input  logic [NBANK-1:0]  cfg_bank_en,
    output loc_t              loc
);

    always_comb begin
        loc = split_addr(addr, cfg_size, cfg_bank_en);
    end

    // R2: the column never exceeds the configured side width
    always_comb begin
        assert ((32'(loc.col) >> side_bits(cfg_size)) == 0)
            else $error("p_col_width_r2");
    end

endmodule

// File: rtl/pgdram_refresh_timer.sv
module pgdram_refresh_timer #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pend
);

    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + CW'(1);
            if (tick)       pend <= 1'b1;
            else if (start) pend <= 1'b0;
        end
    end

    p_tick_raises_r8: assert property (@(posedge clk) disable iff (rst)
        tick |=> pend);

    p_start_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> pend);

endmodule

// File: rtl/pgdram_page_track.sv
module pgdram_page_track
    import pgdram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              open_en,
    input  logic [BANK_W-1:0] open_bank,
    input  logic [DA_W-1:0]   open_row,
    input  logic              close,
    input  logic [BANK_W-1:0] cmp_bank,
    input  logic [DA_W-1:0]   cmp_row,
    output logic              open_valid,
    output logic [BANK_W-1:0] cur_bank,
    output logic [DA_W-1:0]   cur_row,
    output logic              hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_valid <= 1'b0;
            cur_bank   <= '0;
            cur_row    <= '0;
        end else if (close) begin
            open_valid <= 1'b0;
        end else if (open_en) begin
            open_valid <= 1'b1;
            cur_bank   <= open_bank;
            cur_row    <= open_row;
        end
    end

    assign hit = open_valid && (cur_bank == cmp_bank) && (cur_row == cmp_row);

    p_closed_after_ref_r9: assert property (@(posedge clk) disable iff (rst)
        close |=> !open_valid);

    p_opened_row_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (open_en && !close) |=> (open_valid && cur_row == $past(open_row)));

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REF_PERIOD = 512,
    parameter int REF_BURST  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_size,
    input  logic [NBANK-1:0]  cfg_bank_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DA_W-1:0]   dram_addr,
    output logic [NBANK-1:0]  dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    localparam int BW = (REF_BURST > 2) ? $clog2(REF_BURST) : 1;

    st_t               state, state_nx;
    loc_t              in_loc;
    loc_t              r_loc;
    logic              r_we;
    logic [DATA_W-1:0] r_wdata;
    logic [BW-1:0]     burst_cnt;
    logic              ref_pend;
    logic              ref_start;
    logic              accept;
    logic              open_valid;
    logic [BANK_W-1:0] open_bank;
    logic [DA_W-1:0]   open_row;
    logic              page_hit;

    pgdram_addr_map u_map (
        .addr        (req_addr),
        .cfg_size    (cfg_size),
        .cfg_bank_en (cfg_bank_en),
        .loc         (in_loc)
    );

    pgdram_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (ref_start),
        .pend  (ref_pend)
    );

    pgdram_page_track u_page (
        .clk        (clk),
        .rst        (rst),
        .open_en    (state == ST_ROW),
        .open_bank  (r_loc.bank),
        .open_row   (r_loc.row),
        .close      (ref_start),
        .cmp_bank   (in_loc.bank),
        .cmp_row    (in_loc.row),
        .open_valid (open_valid),
        .cur_bank   (open_bank),
        .cur_row    (open_row),
        .hit        (page_hit)
    );

    assign req_ready = (state == ST_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign ref_start = (state == ST_IDLE) && ref_pend;

    // Sequencer
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (ref_pend)                state_nx = ST_RPRE;
                else if (accept) begin
                    if (!in_loc.populated)   state_nx = ST_NOBANK;
                    else if (page_hit)       state_nx = ST_COL;
                    else if (open_valid)     state_nx = ST_PRE;
                    else                     state_nx = ST_ROW;
                end
            end
            ST_PRE:    state_nx = ST_ROW;
            ST_ROW:    state_nx = ST_COL;
            ST_COL:    state_nx = ST_IDLE;
            ST_NOBANK: state_nx = ST_IDLE;
            ST_RPRE:   state_nx = ST_RCAS;
            ST_RCAS:   state_nx = ST_RRAS;
            ST_RRAS:   state_nx = ST_RREC;
            ST_RREC:   state_nx = (burst_cnt == BW'(REF_BURST - 1)) ? ST_IDLE : ST_RCAS;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            r_loc     <= '0;
            r_we      <= 1'b0;
            r_wdata   <= '0;
            burst_cnt <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state <= state_nx;
            if (accept && !ref_pend) begin
                r_loc   <= in_loc;
                r_we    <= req_we;
                r_wdata <= req_wdata;
            end
            if (state == ST_RPRE)      burst_cnt <= '0;
            else if (state == ST_RREC) burst_cnt <= burst_cnt + BW'(1);
            rd_valid <= ((state == ST_COL) || (state == ST_NOBANK)) && !r_we;
            if (state == ST_COL)         rd_data <= dram_rdata;
            else if (state == ST_NOBANK) rd_data <= '1;
        end
    end

    // Strobe and address decode
    always_comb begin
        dram_ras_n = '1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_addr  = r_loc.row;
        case (state)
            ST_IDLE, ST_NOBANK: begin
                if (open_valid) dram_ras_n[open_bank] = 1'b0;
                dram_addr = open_row;
            end
            ST_ROW: begin
                dram_ras_n[r_loc.bank] = 1'b0;
            end
            ST_COL: begin
                dram_ras_n[r_loc.bank] = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !r_we;
                dram_addr  = r_loc.col;
            end
            ST_RCAS: dram_cas_n = 1'b0;
            ST_RRAS: begin
                dram_cas_n = 1'b0;
                dram_ras_n = '0;
            end
            default: ;
        endcase
    end

    assign dram_wdata = r_wdata;

    p_single_bank_r10: assert property (@(posedge clk) disable iff (rst)
        !in_refresh(state) |-> ($countones(~dram_ras_n) <= 1));

    p_ref_holds_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (dram_ras_n == '0) |-> !req_ready);

    p_cbr_order_r8: assert property (@(posedge clk) disable iff (rst)
        (dram_ras_n == '0) |-> (!dram_cas_n && $past(!dram_cas_n)));

    p_hit_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && in_loc.populated && page_hit) |=> (!dram_cas_n && $stable(dram_ras_n)));

    p_miss_pre_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && in_loc.populated && !page_hit && open_valid) |=> (dram_ras_n == '1));

    p_unpop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_loc.populated) |=> (dram_cas_n && $stable(dram_ras_n)));

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_no_accept_in_ref_r8: assert property (@(posedge clk) disable iff (rst)
        in_refresh(state) |-> !req_ready);

endmodule

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;
    import pgdram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int REF_PERIOD = 300;
    localparam int REF_BURST  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_size = 2'd0;
    logic [NBANK-1:0]  cfg_bank_en = '1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_we = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [DA_W-1:0]   dram_addr;
    logic [NBANK-1:0]  dram_ras_n;
    logic              dram_cas_n;
    logic              dram_we_n;
    logic [DATA_W-1:0] dram_wdata;
    logic [DATA_W-1:0] dram_rdata;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pgdram_ctrl #(
        .DATA_W(DATA_W), .REF_PERIOD(REF_PERIOD), .REF_BURST(REF_BURST)
    ) u_pgdram_ctrl (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_bank_en(cfg_bank_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM ----------------
    logic [DATA_W-1:0]     mem [int];
    logic [NBANK*DA_W-1:0] mrow_v = '0;
    logic [NBANK-1:0]      prev_ras = '1;

    function automatic int one_bank(input logic [NBANK-1:0] rn);
        int idx = -1;
        if ($countones(~rn) != 1) return -1;
        for (int b = 0; b < NBANK; b++) if (!rn[b]) idx = b;
        return idx;
    endfunction

    function automatic int mkey(input int b, input logic [DA_W-1:0] row,
                                input logic [DA_W-1:0] col);
        return (b << (2 * DA_W)) | (int'(row) << DA_W) | int'(col);
    endfunction

    function automatic logic [DATA_W-1:0] model_rd(input logic [NBANK-1:0] rn,
                                                   input logic cn,
                                                   input logic [DA_W-1:0] a,
                                                   input logic [NBANK*DA_W-1:0] rv);
        int b = one_bank(rn);
        int k;
        if (cn || b < 0) return '0;
        k = mkey(b, rv[b*DA_W +: DA_W], a);
        return mem.exists(k) ? mem[k] : '0;
    endfunction

    assign dram_rdata = model_rd(dram_ras_n, dram_cas_n, dram_addr, mrow_v);

    always @(posedge clk) begin
        int wb;
        for (int b = 0; b < NBANK; b++)
            if (!dram_ras_n[b] && prev_ras[b] && dram_cas_n)
                mrow_v[b*DA_W +: DA_W] <= dram_addr;
        wb = one_bank(dram_ras_n);
        if (!dram_cas_n && !dram_we_n && wb >= 0)
            mem[mkey(wb, mrow_v[wb*DA_W +: DA_W], dram_addr)] = dram_wdata;
        prev_ras <= dram_ras_n;
    end

    // ---------------- port monitor ----------------
    int     ref_low   = 0;
    int     acc_cnt   = 0;
    int     acc_bank  = 0;
    longint acc_row   = 0;
    longint acc_col   = 0;
    longint bstart_prev = -1;
    longint bstart_last = -1;

    always @(negedge clk) begin
        int ob;
        if (!rst) begin
            if (dram_ras_n == '0) begin
                if (ref_low % REF_BURST == 0) begin
                    bstart_prev = bstart_last;
                    bstart_last = cyc;
                end
                ref_low++;
                // R8: held off, CAS-before-RAS
                chk(!req_ready && !dram_cas_n, "R8", "ready/cas during refresh",
                    {req_ready, dram_cas_n}, 0);
            end else begin
                chk($countones(~dram_ras_n) <= 1, "R10", "ras lines low",
                    $countones(~dram_ras_n), 1);
            end
            ob = one_bank(dram_ras_n);
            if (!dram_cas_n && ob >= 0) begin
                acc_cnt++;
                acc_bank = ob;
                acc_col  = dram_addr;
                acc_row  = mrow_v[ob*DA_W +: DA_W];
            end
        end
    end

    // ---------------- bench page model and reference ----------------
    logic [DATA_W-1:0] refm [longint];
    bit     b_open = 0;
    int     b_bank = 0;
    longint b_row  = 0;
    int     ref_snap = 0;

    task automatic do_op(input bit we, input longint addr, input logic [DATA_W-1:0] wd);
        int     n = 9 + ((cfg_size == 2'd3) ? 2 : int'(cfg_size));
        longint col = addr & ((64'd1 << n) - 1);
        longint row = (addr >> n) & ((64'd1 << n) - 1);
        longint ext = addr >> (2 * n);
        bit     pop = (ext < NBANK) && cfg_bank_en[ext[1:0]];
        int     lat;
        string  tag;
        bit     after_ref;
        int     acc_before;
        int     seen;
        logic [DATA_W-1:0] got = '0;

        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = ADDR_W'(addr); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        after_ref = (ref_low != ref_snap);
        if (after_ref) b_open = 0;
        acc_before = acc_cnt;
        @(posedge clk);
        ref_snap = ref_low;
        if (!pop)                                         begin lat = 1; tag = "R7"; end
        else if (b_open && b_bank == int'(ext) && b_row == row) begin lat = 1; tag = "R4"; end
        else if (b_open)                                  begin lat = 3; tag = "R6"; end
        else                                              begin lat = 2; tag = after_ref ? "R9" : "R5"; end
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (int i = 1; i <= 40; i++) begin
            if (i > 1) @(negedge clk);
            if (rd_valid) begin
                if (seen == 0) begin seen = i; got = rd_data; end
            end
            if (we && req_ready) break;
            if (!we && seen != 0) break;
        end
        if (we) begin
            chk(seen == 0, "R10", "rd_valid on write", seen, 0);
        end else begin
            chk(seen - 1 == lat, tag, "read latency (edges)", seen - 1, lat);
            chk(got == (pop ? (refm.exists(addr) ? refm[addr] : '0) : '1),
                pop ? "R3" : "R7", "read data", got,
                pop ? (refm.exists(addr) ? refm[addr] : '0) : '1);
        end
        if (pop) begin
            chk(acc_bank == int'(ext) && acc_row == row && acc_col == col, "R2",
                "bank/row/col on bus", (longint'(acc_bank) << 24) | (acc_row << 12) | acc_col,
                (ext << 24) | (row << 12) | col);
            b_open = 1; b_bank = int'(ext); b_row = row;
            if (we) refm[addr] = wd;
        end else begin
            chk(acc_cnt == acc_before, "R7", "column cycles for empty bank",
                acc_cnt - acc_before, 0);
        end
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic [NBANK-1:0] en);
        @(negedge clk);
        rst = 1'b1; cfg_size = sz; cfg_bank_en = en;
        mem.delete(); refm.delete();
        b_open = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ref_snap = ref_low;
        @(negedge clk);
        chk(req_ready && dram_ras_n == '1 && dram_cas_n && !rd_valid, "R1",
            "reset state", {req_ready, dram_ras_n, dram_cas_n, rd_valid}, 7'b1111110);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [1:0]       szs [3] = '{2'd0, 2'd1, 2'd3};
        logic [NBANK-1:0] ens [3] = '{4'b1101, 4'b0111, 4'b1111};
        void'($urandom(32'h00c0ffee));
        for (int p = 0; p < 3; p++) begin
            int     n;
            longint a, bb, un;
            longint pool [6];
            longint wlist [16];
            int     wcnt = 0;
            int     r0;
            do_reset(szs[p], ens[p]);
            n  = 9 + ((szs[p] == 2'd3) ? 2 : int'(szs[p]));
            a  = (longint'(5) << n) | 3;                 // bank 0, row 5
            bb = (longint'(2) << (2 * n)) | (longint'(5) << n) | 7; // bank 2, row 5
            un = (p == 0) ? (longint'(1) << (2 * n)) | 9 :  // masked bank
                 (p == 1) ? (longint'(3) << (2 * n)) | 9 :  // masked bank
                            (longint'(1) << (2 * n)) | 9;   // fitted
            do_op(1, a, 8'h5A);          // R5 path
            do_op(0, a, 0);              // R4 hit, R3 data
            do_op(1, a + 1, 8'hC3);
            do_op(0, a + 1, 0);          // R4
            do_op(0, bb, 0);             // R6 bank change
            do_op(0, a, 0);              // R6 back
            do_op(0, a + (longint'(1) << n), 0); // R6 row change same bank
            if (p < 2) begin
                do_op(0, un, 0);         // R7 read all ones
                do_op(1, un, 8'h11);     // R7 write dropped
                do_op(0, un, 0);
            end else begin
                do_op(0, (longint'(7) << (2 * 9)) | 4, 0);
            end
            // wait idle across two refresh batches (R8 spacing, R9 close)
            r0 = ref_low;
            for (int i = 0; i < 3 * REF_PERIOD && ref_low < r0 + 2 * REF_BURST; i++)
                @(negedge clk);
            chk(bstart_last - bstart_prev == REF_PERIOD, "R8", "refresh spacing",
                bstart_last - bstart_prev, REF_PERIOD);
            do_op(0, a, 0);              // R9 closed after refresh
            for (int i = 0; i < 6; i++)
                pool[i] = longint'($urandom()) & ((longint'(1) << (2 * n + 2 + (p < 2 ? 1 : 0))) - 1);
            for (int k = 0; k < 140; k++) begin
                int     sel  = int'($urandom_range(5));
                longint ad   = (pool[sel] & ~((longint'(1) << n) - 1)) | longint'($urandom_range(7));
                bit     w    = ($urandom_range(2) == 0);
                if (!w && wcnt > 0 && $urandom_range(1) == 0)
                    ad = wlist[$urandom_range(wcnt - 1)];
                ad = ad & ((longint'(1) << ADDR_W) - 1);
                do_op(w, ad, DATA_W'($urandom()));
                if (w && wcnt < 16) begin wlist[wcnt] = ad; wcnt++; end
            end
            while (!req_ready) @(negedge clk);
            chk(ref_low > 0 && ref_low % REF_BURST == 0, "R8", "refresh cycles per batch",
                ref_low % REF_BURST, 0);
        end
        summary();
    end

endmodule